// File: doc/BRIEF.md
# Palette DAC Host Register File

This block is the host-facing register file of a colour lookup DAC with 256 palette entries. A host writes an index into an address register. It then streams colour components through a single colour-map port, or reaches a small window of control registers through the same index. Every value the host writes or reads travels in the most significant byte of a 32-bit bus word. The remaining bits are ignored on write and returned as zero on read.

A palette entry is loaded as three successive colour-map writes: red, then green, then blue. The entry is committed to storage only on the blue write. After that, the component sequence returns to red and the address advances by one, so a run of entries can be loaded with one address write. The control window holds a pixel read mask, an overlay/cursor control register that software changes by read-modify-write, and two spare registers.

A separate pixel lookup port takes an 8-bit pixel index, ANDs it with the read mask, and returns the 24-bit colour stored at that index one clock later. Analog output and video timing belong to other blocks.

Top module: `clut_regfile`

## Requirements
- R1: Only bits 31:24 of `host_wdata` carry the index, colour or control value; bits 23:0 have no effect. Reads return the value in bits 31:24 with bits 23:0 zero.
- R2: A write with `host_sel`=0 (address port) loads the index and returns the component sequence to red. A partly loaded entry is abandoned. A read with `host_sel`=0 returns the current index.
- R3: With `host_sel`=1 (colour-map port), three writes supply red, green and blue in that order. On the blue write the entry at the current index becomes {red, green, blue}, with red in bits 23:16 and blue in bits 7:0.
- R4: After only the red and green writes of a triple, the stored entry still holds its previous colour.
- R5: After each committed entry the index increments by one, wrapping from 255 to 0.
- R6: After reset, control registers read 0xFF (index 4, read mask), 0x00 (index 5), 0x73 (index 6, overlay/cursor control) and 0x00 (index 7).
- R7: With `host_sel`=2 (control port), writes and reads act on the control register selected by the current index. The written value is read back unchanged. For indexes outside 4..7, writes are ignored and reads return 0.
- R8: `pix_rgb` shows the entry at (`pix_idx` AND read mask), one clock after `pix_idx` is sampled.
- R9: Control-port accesses change neither the index nor the position in the red/green/blue sequence.
- R10: While reset is high, `host_rdata` and `pix_rgb` are zero. After reset, the index is 0 and the sequence starts at red.
- R11: `host_rdata` updates on the clock edge that samples `host_re` and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_sel | input | 2 | Port select: 0 address, 1 colour map, 2 control, 3 unused |
| host_wdata | input | 32 | Host write word, value in bits 31:24 |
| host_rdata | output | 32 | Registered read word, value in bits 31:24 |
| pix_idx | input | 8 | Pixel index to look up |
| pix_rgb | output | 24 | Registered colour {R,G,B} for the masked pixel |

## Verification
The bench builds the block with its default parameters: 8-bit lanes in the top byte of a 32-bit word, 256 entries, and a control window at indexes 4 to 7. With these values the index wraps from 255 to 0 within a single triple. All four control registers and indexes on both sides of the window can be reached. Read masks narrower than the index fold distinct pixel values onto one entry.

// File: rtl/clut_pkg.sv
package clut_pkg;
  typedef enum logic [1:0] {
    PORT_ADDR = 2'd0,
    PORT_CMAP = 2'd1,
    PORT_CTRL = 2'd2,
    PORT_RSVD = 2'd3
  } port_e;

  typedef enum logic [1:0] {
    COMP_RED = 2'd0,
    COMP_GRN = 2'd1,
    COMP_BLU = 2'd2
  } comp_e;
endpackage

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CH_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               addr_we,
  input  logic               cmap_we,
  input  logic               ctrl_acc,
  input  logic [CH_W-1:0]    wbyte,
  output logic [IDX_W-1:0]   cur_addr,
  output logic               mem_we,
  output logic [IDX_W-1:0]   mem_addr,
  output logic [3*CH_W-1:0]  mem_data
);
  comp_e             comp;
  logic [CH_W-1:0]   red_q;
  logic [CH_W-1:0]   grn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      comp     <= COMP_RED;
      red_q    <= '0;
      grn_q    <= '0;
    end else if (addr_we) begin
      cur_addr <= wbyte[IDX_W-1:0];
      comp     <= COMP_RED;
    end else if (cmap_we) begin
      case (comp)
        COMP_RED: begin red_q <= wbyte; comp <= COMP_GRN; end
        COMP_GRN: begin grn_q <= wbyte; comp <= COMP_BLU; end
        COMP_BLU: begin comp <= COMP_RED; cur_addr <= cur_addr + IDX_W'(1); end
        default:  comp <= COMP_RED;
      endcase
    end
  end

  always_comb begin
    mem_we   = cmap_we && !addr_we && (comp == COMP_BLU);
    mem_addr = cur_addr;
    mem_data = {red_q, grn_q, wbyte};
  end

  // R2: an address write restarts the sequence at red
  a_r2_addr_restarts: assert property (@(posedge clk) disable iff (rst)
    addr_we |=> (comp == COMP_RED));
  // R5: a committed entry advances the index by one
  a_r5_addr_advance: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (cur_addr == IDX_W'($past(cur_addr) + IDX_W'(1))));
  // R9: control accesses leave index and sequence untouched
  a_r9_ctrl_no_touch: assert property (@(posedge clk) disable iff (rst)
    (ctrl_acc && !addr_we && !cmap_we) |=> ($stable(cur_addr) && $stable(comp)));
  // R3: sequence position never leaves red/green/blue
  a_r3_comp_range: assert property (@(posedge clk) disable iff (rst)
    comp != 2'd3);
endmodule

// File: rtl/clut_ctrl_bank.sv
module clut_ctrl_bank #(
  parameter int                   IDX_W = 8,
  parameter int                   CH_W  = 8,
  parameter int                   BASE  = 4,
  parameter int                   NUM   = 4,
  parameter logic [NUM*CH_W-1:0]  INIT  = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] sel_idx,
  input  logic [CH_W-1:0]  wbyte,
  output logic [CH_W-1:0]  rd_byte,
  output logic [CH_W-1:0]  mask
);
  localparam int OFF_W = (NUM > 1) ? $clog2(NUM) : 1;

  logic [CH_W-1:0]  regs [NUM];
  logic [IDX_W-1:0] off;
  logic             hit;

  always_comb begin
    off = sel_idx - IDX_W'(BASE);
    hit = (sel_idx >= IDX_W'(BASE)) && (off < IDX_W'(NUM));
  end

  for (genvar g = 0; g < NUM; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= INIT[g*CH_W +: CH_W];
      else if (we && hit && (off == IDX_W'(g)))
        regs[g] <= wbyte;
    end
  end

  always_comb begin
    rd_byte = hit ? regs[off[OFF_W-1:0]] : '0;
    mask    = regs[0];
  end

  // R6: the read mask leaves reset at its initial value
  a_r6_mask_init: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mask == INIT[CH_W-1:0]));
  // R7: writes outside the window leave the mask unchanged
  a_r7_outside_ignored: assert property (@(posedge clk) disable iff (rst)
    (we && !hit) |=> $stable(mask));
endmodule

// File: rtl/clut_palette_ram.sv
module clut_palette_ram #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 24,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/clut_regfile.sv
module clut_regfile
  import clut_pkg::*;
#(
  parameter int BUS_W     = 32,
  parameter int CH_W      = 8,
  parameter int CTRL_BASE = 4,
  parameter int CTRL_NUM  = 4,
  parameter logic [CTRL_NUM*CH_W-1:0] CTRL_INIT = {8'h00, 8'h73, 8'h00, 8'hFF}
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_we,
  input  logic                host_re,
  input  logic [1:0]          host_sel,
  input  logic [BUS_W-1:0]    host_wdata,
  output logic [BUS_W-1:0]    host_rdata,
  input  logic [CH_W-1:0]     pix_idx,
  output logic [3*CH_W-1:0]   pix_rgb
);
  localparam int IDX_W    = CH_W;
  localparam int DEPTH    = 1 << IDX_W;
  localparam int LANE_LSB = BUS_W - CH_W;

  port_e             sel;
  logic [CH_W-1:0]   wbyte;
  logic              addr_we, cmap_we, ctrl_we, ctrl_acc;
  logic [IDX_W-1:0]  cur_addr;
  logic              mem_we;
  logic [IDX_W-1:0]  mem_addr;
  logic [3*CH_W-1:0] mem_data;
  logic [CH_W-1:0]   ctrl_rd;
  logic [CH_W-1:0]   mask;
  logic [IDX_W-1:0]  look_addr;

  always_comb begin
    sel       = port_e'(host_sel);
    wbyte     = host_wdata[LANE_LSB +: CH_W];
    addr_we   = host_we && (sel == PORT_ADDR);
    cmap_we   = host_we && (sel == PORT_CMAP);
    ctrl_we   = host_we && (sel == PORT_CTRL);
    ctrl_acc  = (host_we || host_re) && (sel == PORT_CTRL);
    look_addr = pix_idx & mask;
  end

  clut_seq #(.IDX_W(IDX_W), .CH_W(CH_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .addr_we  (addr_we),
    .cmap_we  (cmap_we),
    .ctrl_acc (ctrl_acc),
    .wbyte    (wbyte),
    .cur_addr (cur_addr),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_data (mem_data)
  );

  clut_ctrl_bank #(
    .IDX_W(IDX_W), .CH_W(CH_W), .BASE(CTRL_BASE), .NUM(CTRL_NUM), .INIT(CTRL_INIT)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .we      (ctrl_we),
    .sel_idx (cur_addr),
    .wbyte   (wbyte),
    .rd_byte (ctrl_rd),
    .mask    (mask)
  );

  clut_palette_ram #(.DEPTH(DEPTH), .DATA_W(3*CH_W)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (mem_we),
    .waddr (mem_addr),
    .wdata (mem_data),
    .raddr (look_addr),
    .rdata (pix_rgb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_re) begin
      case (sel)
        PORT_ADDR: host_rdata <= {cur_addr, {LANE_LSB{1'b0}}};
        PORT_CTRL: host_rdata <= {ctrl_rd, {LANE_LSB{1'b0}}};
        default:   host_rdata <= '0;
      endcase
    end
  end

  // R3: palette storage is written only by a colour-map write
  a_r3_commit_source: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (host_we && host_sel == 2'd1));
  // R1: the low bits of a read word are always zero
  a_r1_low_zero: assert property (@(posedge clk) disable iff (rst)
    host_rdata[LANE_LSB-1:0] == '0);
  // R11: read data holds when no read is strobed
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !host_re |=> $stable(host_rdata));
endmodule

// File: tb/sim_clut_regfile.sv
module sim_clut_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic        host_re = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_rgb;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  clut_regfile u0 (
    .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pix_idx(pix_idx), .pix_rgb(pix_rgb)
  );

  // {index, red, green, blue}
  localparam logic [31:0] TBL [6] = '{
    32'h00_11_22_33, 32'h0F_12_34_56, 32'h80_A0_B0_C0,
    32'hFE_FF_00_FF, 32'h55_5A_A5_3C, 32'h01_01_02_03
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel = s; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0; host_wdata = 32'h0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk);
    host_re = 1'b1; host_sel = s;
    @(negedge clk);
    host_re = 1'b0;
    v = host_rdata;
  endtask

  task automatic look(input logic [7:0] p, output logic [23:0] v);
    @(negedge clk);
    pix_idx = p;
    @(negedge clk);
    v = pix_rgb;
  endtask

  task automatic load(input logic [7:0] idx, input logic [23:0] c);
    wr(2'd0, {idx, 24'hC0FFEE});
    wr(2'd1, {c[23:16], 24'hABCDEF});
    wr(2'd1, {c[15:8], 24'h123456});
    wr(2'd1, {c[7:0], 24'hFFFFFF});
  endtask

  initial begin
    #(4 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [23:0] c;
    repeat (3) @(negedge clk);
    // R10: outputs zero during reset
    chk("R10 rdata in reset", host_rdata, 32'h0);
    chk("R10 rgb in reset", {8'h0, pix_rgb}, 32'h0);
    rst = 1'b0;
    rd(2'd0, v); chk("R10 index after reset", v, 32'h0);
    // R6: control reset values
    wr(2'd0, 32'h04_000000); rd(2'd2, v); chk("R6 reg4", v, 32'hFF000000);
    wr(2'd0, 32'h05_000000); rd(2'd2, v); chk("R6 reg5", v, 32'h00000000);
    wr(2'd0, 32'h06_000000); rd(2'd2, v); chk("R6 reg6", v, 32'h73000000);
    wr(2'd0, 32'h07_000000); rd(2'd2, v); chk("R6 reg7", v, 32'h00000000);

    // R1 R3: table of entries loaded with junk in low bits
    foreach (TBL[i]) load(TBL[i][31:24], TBL[i][23:0]);
    foreach (TBL[i]) begin
      look(TBL[i][31:24], c);
      chk("R3 R1 table entry", {8'h0, c}, {8'h0, TBL[i][23:0]});
    end

    // R4: no commit before blue
    load(8'h10, 24'h0A0B0C);
    wr(2'd0, 32'h10_000000);
    wr(2'd1, 32'h77_000000); wr(2'd1, 32'h88_000000);
    look(8'h10, c); chk("R4 partial triple", {8'h0, c}, 32'h000A0B0C);
    wr(2'd1, 32'h99_000000);
    look(8'h10, c); chk("R3 after blue", {8'h0, c}, 32'h00778899);

    // R5: auto-increment and wrap
    wr(2'd0, 32'h20_000000);
    wr(2'd1, 32'h01_000000); wr(2'd1, 32'h02_000000); wr(2'd1, 32'h03_000000);
    wr(2'd1, 32'h04_000000); wr(2'd1, 32'h05_000000); wr(2'd1, 32'h06_000000);
    look(8'h20, c); chk("R5 first streamed", {8'h0, c}, 32'h00010203);
    look(8'h21, c); chk("R5 second streamed", {8'h0, c}, 32'h00040506);
    rd(2'd0, v); chk("R5 index advanced", v, 32'h22000000);
    load(8'hFF, 24'hDEAD01);
    rd(2'd0, v); chk("R5 wrap to zero", v, 32'h00000000);
    look(8'hFF, c); chk("R5 entry 255", {8'h0, c}, 32'h00DEAD01);

    // R2: address write abandons partial triple
    wr(2'd0, 32'h30_000000);
    wr(2'd1, 32'hE1_000000); wr(2'd1, 32'hE2_000000);
    wr(2'd0, 32'h31_000000);
    wr(2'd1, 32'h41_000000); wr(2'd1, 32'h42_000000); wr(2'd1, 32'h43_000000);
    look(8'h31, c); chk("R2 restart at red", {8'h0, c}, 32'h00414243);

    // R9 R7: control access mid-triple, index outside window
    wr(2'd0, 32'h40_000000);
    wr(2'd1, 32'h61_000000); wr(2'd1, 32'h62_000000);
    wr(2'd2, 32'h5A_000000);
    rd(2'd2, v); chk("R7 outside window reads 0", v, 32'h0);
    wr(2'd1, 32'h63_000000);
    look(8'h40, c); chk("R9 triple intact", {8'h0, c}, 32'h00616263);
    rd(2'd0, v); chk("R9 index after", v, 32'h41000000);

    // R7: control write/readback and read-modify-write
    wr(2'd0, 32'h05_000000); wr(2'd2, 32'hA5_FFFFFF);
    rd(2'd2, v); chk("R7 reg5 readback", v, 32'hA5000000);
    wr(2'd0, 32'h06_000000); rd(2'd2, v);
    wr(2'd2, {v[31:24] & 8'hFC, 24'h0});
    rd(2'd2, v); chk("R7 reg6 rmw", v, 32'h70000000);
    wr(2'd0, 32'h03_000000); wr(2'd2, 32'h55_000000);
    rd(2'd2, v); chk("R7 index 3 ignored", v, 32'h0);
    wr(2'd0, 32'h08_000000); wr(2'd2, 32'h55_000000);
    rd(2'd2, v); chk("R7 index 8 ignored", v, 32'h0);
    wr(2'd0, 32'h04_000000); rd(2'd2, v); chk("R7 mask untouched", v, 32'hFF000000);

    // R8: read mask folds pixel index
    wr(2'd2, 32'h0F_000000);
    look(8'hFF, c); chk("R8 masked 0xFF", {8'h0, c}, 32'h00123456);
    look(8'h2F, c); chk("R8 masked 0x2F", {8'h0, c}, 32'h00123456);
    wr(2'd2, 32'hFF_000000);
    // R8: one-cycle latency, old value before edge
    look(8'h00, c);
    @(negedge clk); pix_idx = 8'h80;
    #1 chk("R8 before edge", {8'h0, pix_rgb}, 32'h00112233);
    @(negedge clk); chk("R8 after edge", {8'h0, pix_rgb}, 32'h00A0B0C0);

    // R11: rdata holds without read
    wr(2'd0, 32'h06_000000); rd(2'd2, v);
    wr(2'd0, 32'h07_000000);
    chk("R11 rdata held", host_rdata, 32'h70000000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule